// File: doc/BRIEF.md
# Two-Bit Pixel Word Output Serializer

This block takes one 16-bit conversion result per pixel period and sends it over a two-line output bus in eight consecutive output slots. A pixel-start marker loads a new word and presents its first slot. Each following slot strobe moves the bus on by one slot. The word loaded at a marker is the one that was presented four markers earlier, which gives a fixed four-pixel output latency. That latency does not depend on how the word was produced.

Both output rates run in one synchronous clock domain, and the slot strobe chooses between them. When one slot lasts a full sample clock period, the strobe is high on every second cycle of a clock at twice the sample rate. When one slot lasts half a sample clock period, the strobe is high on every cycle. A select bit picks the bit order. In the pair order, the upper line carries the odd bits and the lower line the even bits, both from the top down. In the byte order, the upper line carries the high byte and the lower line the low byte, most significant bit first. A drive-disable input releases the two lines through an output-enable flag.

Words enter as a valid-only stream: the marker acts as the valid qualifier and `pix_word` is its payload. There is no ready and no back-pressure. The source is a converter that cannot stall, so a word must be present on every marker, and the block never refuses one.

Top module: `pix2_serializer`

## Requirements
- R1: While reset is asserted, `line_hi`, `line_lo` and `line_oe` are all 0, and the bit order returns to pairs (`split_order` = 0).
- R2: The word sent after the k-th marker since reset is the `pix_word` presented at marker k-4. The words sent after the first four markers are all zero.
- R3: With `split_order` = 0, slot s (s = 0..7) carries word bit 15-2s on `line_hi` and word bit 14-2s on `line_lo`.
- R4: With `split_order` = 1, slot s carries word bit 15-s on `line_hi` and word bit 7-s on `line_lo`.
- R5: `split_order` is sampled only in the marker cycle. A change between markers has no effect on the word being sent.
- R6: Slot 0 appears on the lines in the cycle after the marker edge. Each strobe edge after that advances one slot. Once slot 7 is reached, further strobes and idle cycles leave both lines unchanged until the next marker.
- R7: A marker that arrives together with a strobe restarts the sequence at slot 0 of the newly loaded word.
- R8: `line_oe` equals the inverse of `drive_off` one clock later. Serialization carries on while the lines are released.
- R9: The slot rate is set only by the strobe spacing. Strobes on every cycle and strobes on every second cycle deliver the same eight slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at twice the sample clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_stb | input | 1 | Advances the output by one slot |
| pix_start | input | 1 | Pixel-start marker; qualifies `pix_word` |
| pix_word | input | 16 | Conversion result for this pixel |
| split_order | input | 1 | 0 = pair order, 1 = byte order |
| drive_off | input | 1 | 1 releases the output lines |
| line_hi | output | 1 | Upper output line |
| line_lo | output | 1 | Lower output line |
| line_oe | output | 1 | 1 while the lines are driven |

## Verification
The assertions assume that markers and strobes are synchronous single-cycle levels. They also assume that at least seven strobes arrive between markers whenever a full word is expected. The latency property further assumes that a marker is the only event that loads a word. The stimulus sends each pixel as a marker followed by seven or more strobes. It spaces them one or two cycles apart, sometimes adds extra strobes past the last slot, and sometimes overlaps a strobe with the marker. Because it never truncates a pixel, every reconstructed word is complete.

// File: rtl/pix2_pkg.sv
package pix2_pkg;
  typedef enum logic {
    ORD_PAIRS = 1'b0,
    ORD_BYTES = 1'b1
  } lane_order_e;
endpackage

// File: rtl/pix2_word_delay.sv
module pix2_word_delay #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  // One stage per pixel of latency; advances only on a pixel marker.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WORD_W-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= g_stage[i-1].q;
      end
    end
  end

  // Value before the shift: the word entered DEPTH markers ago.
  assign dout = g_stage[DEPTH-1].q;
endmodule

// File: rtl/pix2_slot_seq.sv
module pix2_slot_seq #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              adv
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;

  // Marker wins over a strobe; the counter parks on the last slot.
  always_comb begin
    adv      = start | (step & (slot_q != LAST));
    slot_nxt = start ? '0 : slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   slot_q <= LAST;
    else if (adv) slot_q <= slot_nxt;
  end
endmodule

// File: rtl/pix2_lane_mux.sv
module pix2_lane_mux
  import pix2_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SLOT_W = 3
) (
  input  logic [WORD_W-1:0] word,
  input  lane_order_e       order,
  input  logic [SLOT_W-1:0] slot,
  output logic              bit_hi,
  output logic              bit_lo
);
  localparam int SLOTS = WORD_W / 2;
  localparam int HALF  = WORD_W / 2;

  logic [SLOTS-1:0] pair_hi, pair_lo, byte_hi, byte_lo;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign pair_hi[s] = word[WORD_W-1-2*s];
    assign pair_lo[s] = word[WORD_W-2-2*s];
    assign byte_hi[s] = word[WORD_W-1-s];
    assign byte_lo[s] = word[HALF-1-s];
  end

  always_comb begin
    if (order == ORD_BYTES) begin
      bit_hi = byte_hi[slot];
      bit_lo = byte_lo[slot];
    end else begin
      bit_hi = pair_hi[slot];
      bit_lo = pair_lo[slot];
    end
  end
endmodule

// File: rtl/pix2_serializer.sv
module pix2_serializer
  import pix2_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int LAT_PIX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb,
  input  logic              pix_start,
  input  logic [WORD_W-1:0] pix_word,
  input  logic              split_order,
  input  logic              drive_off,
  output logic              line_hi,
  output logic              line_lo,
  output logic              line_oe
);
  localparam int SLOTS  = WORD_W / 2;
  localparam int SLOT_W = $clog2(SLOTS);

  logic [WORD_W-1:0] dly_word, cur_word, sel_word;
  lane_order_e       cur_order, sel_order;
  logic [SLOT_W-1:0] slot_nxt;
  logic              adv, bit_hi, bit_lo;

  pix2_word_delay #(.WORD_W(WORD_W), .DEPTH(LAT_PIX)) u_delay (
    .clk(clk), .rst_n(rst_n), .shift(pix_start), .din(pix_word), .dout(dly_word)
  );

  pix2_slot_seq #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(pix_start), .step(slot_stb),
    .slot_nxt(slot_nxt), .adv(adv)
  );

  // In the marker cycle the mux looks at the word being loaded.
  always_comb begin
    sel_word  = pix_start ? dly_word : cur_word;
    sel_order = pix_start ? lane_order_e'(split_order) : cur_order;
  end

  pix2_lane_mux #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_mux (
    .word(sel_word), .order(sel_order), .slot(slot_nxt),
    .bit_hi(bit_hi), .bit_lo(bit_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_word  <= '0;
      cur_order <= ORD_PAIRS;
      line_hi   <= 1'b0;
      line_lo   <= 1'b0;
      line_oe   <= 1'b0;
    end else begin
      line_oe <= ~drive_off;
      if (pix_start) begin
        cur_word  <= dly_word;
        cur_order <= lane_order_e'(split_order);
      end
      if (adv) begin
        line_hi <= bit_hi;
        line_lo <= bit_lo;
      end
    end
  end
endmodule

// File: rtl/pix2_serializer_chk.sv
module pix2_serializer_chk #(
  parameter int WORD_W  = 16,
  parameter int LAT_PIX = 4
) (
  input logic clk,
  input logic rst_n,
  input logic slot_stb,
  input logic pix_start,
  input logic drive_off,
  input logic line_hi,
  input logic line_lo,
  input logic line_oe
);
  localparam int SLOTS = WORD_W / 2;
  localparam int SW    = $clog2(SLOTS);
  localparam int MW    = $clog2(LAT_PIX + 2) + 1;
  localparam logic [SW-1:0] LAST   = SW'(SLOTS - 1);
  localparam logic [MW-1:0] MK_TOP = MW'(LAT_PIX + 1);
  localparam logic [MW-1:0] MK_LAT = MW'(LAT_PIX);

  logic [SW-1:0] seen_slot;
  logic [MW-1:0] mk_cnt;

  // Independent slot and marker tallies, kept at the ports.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_slot <= LAST;
      mk_cnt    <= '0;
    end else begin
      if (pix_start)                          seen_slot <= '0;
      else if (slot_stb && seen_slot != LAST) seen_slot <= seen_slot + SW'(1);
      if (pix_start && mk_cnt != MK_TOP)      mk_cnt <= mk_cnt + MW'(1);
    end
  end

  p_parked_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_slot == LAST && !pix_start) |=> ($stable(line_hi) && $stable(line_lo)));

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_start && !slot_stb) |=> ($stable(line_hi) && $stable(line_lo)));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_off |=> !line_oe);

  p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_off |=> line_oe);

  p_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_cnt <= MK_LAT) |-> (!line_hi && !line_lo));
endmodule

bind pix2_serializer pix2_serializer_chk #(.WORD_W(WORD_W), .LAT_PIX(LAT_PIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .pix_start(pix_start),
  .drive_off(drive_off), .line_hi(line_hi), .line_lo(line_lo), .line_oe(line_oe)
);

// File: tb/tb_pix2_serializer.sv
module tb_pix2_serializer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_stb, pix_start, split_order, drive_off;
  logic [15:0] pix_word;
  logic        line_hi, line_lo, line_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] hist[$];
  logic [15:0] exp_w[$];
  logic        exp_o[$];

  always #10 clk = ~clk;

  pix2_serializer dut (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .pix_start(pix_start),
    .pix_word(pix_word), .split_order(split_order), .drive_off(drive_off),
    .line_hi(line_hi), .line_lo(line_lo), .line_oe(line_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: pushes the expected word (4 markers back, R2) and the order
  // latched at the marker (R5), then drives the marker and the strobes.
  task automatic drive_pixel(input logic [15:0] w, input logic ord, input int gap,
                             input int extra, input bit coinc, input bit flip, input bit doff);
    logic [15:0] e;
    hist.push_back(w);
    e = (hist.size() > 4) ? hist.pop_front() : 16'h0000;
    exp_w.push_back(e);
    exp_o.push_back(ord);
    @(negedge clk);
    pix_start = 1'b1; pix_word = w; split_order = ord;
    slot_stb = coinc;  // R7: strobe overlapping the marker
    drive_off = doff;
    @(negedge clk);
    pix_start = 1'b0; slot_stb = 1'b0;
    if (flip) split_order = ~ord;  // R5: late change must be ignored
    for (int k = 0; k < 7 + extra; k++) begin
      repeat (gap) @(negedge clk);  // R9: spacing 0 or 1 idle cycles
      slot_stb = 1'b1;
      @(negedge clk);
      slot_stb = 1'b0;
    end
    drive_off = 1'b0;
  endtask

  // Monitor: rebuilds each word from the two lines and compares.
  initial begin
    int          slot = 8;
    logic        ordc = 1'b0;
    logic [15:0] rb = '0, ew = '0;
    logic        mk, st, rs, dof, ph = 1'b0, pl = 1'b0;
    forever begin
      @(posedge clk);
      mk = pix_start; st = slot_stb; rs = rst_n; dof = drive_off;
      #5;
      if (!rs) begin slot = 8; continue; end
      check(line_oe == ~dof, "R8 output enable", {31'b0, line_oe}, {31'b0, ~dof});
      if (mk) begin
        ew = exp_w.pop_front(); ordc = exp_o.pop_front();
        rb = '0; slot = 0;
      end else if (st && slot < 7) begin
        slot++;
      end else begin
        if (slot == 7 && st)
          check(line_hi == ph && line_lo == pl, "R6 lines stable after last slot",
                {30'b0, line_hi, line_lo}, {30'b0, ph, pl});
        ph = line_hi; pl = line_lo;
        continue;
      end
      if (!ordc) begin rb[15-2*slot] = line_hi; rb[14-2*slot] = line_lo; end
      else       begin rb[15-slot]   = line_hi; rb[7-slot]    = line_lo; end
      if (slot == 7)
        check(rb == ew, ordc ? "R2/R4 byte order word" : "R2/R3 pair order word",
              {16'b0, rb}, {16'b0, ew});
      ph = line_hi; pl = line_lo;
    end
  end

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    rst_n = 1'b0; slot_stb = 1'b0; pix_start = 1'b0; pix_word = '0;
    split_order = 1'b0; drive_off = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet lines and released bus under reset
    check(line_hi == 1'b0 && line_lo == 1'b0, "R1 reset lines", {30'b0, line_hi, line_lo}, 32'h0);
    check(line_oe == 1'b0, "R1 reset enable", {31'b0, line_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // First four pixels flush zeros (R2); mixed rates (R9)
    drive_pixel(16'hFFFF, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    drive_pixel(16'h0000, 1'b1, 1, 0, 1'b0, 1'b0, 1'b0);
    drive_pixel(16'hA5C3, 1'b0, 1, 2, 1'b0, 1'b0, 1'b0);
    drive_pixel(16'h8001, 1'b1, 0, 1, 1'b0, 1'b0, 1'b0);
    // Delayed words appear in both orders (R3, R4)
    drive_pixel(16'h1234, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    drive_pixel(16'h5A5A, 1'b1, 1, 0, 1'b0, 1'b0, 1'b0);
    drive_pixel(16'h00FF, 1'b1, 0, 2, 1'b1, 1'b0, 1'b0);  // R7
    drive_pixel(16'hF00F, 1'b0, 1, 0, 1'b0, 1'b1, 1'b0);  // R5
    drive_pixel(16'h7E81, 1'b1, 0, 0, 1'b0, 1'b1, 1'b1);  // R5, R8
    drive_pixel(16'h3C3C, 1'b0, 0, 1, 1'b1, 1'b0, 1'b1);  // R7, R8
    for (int n = 0; n < 12; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive_pixel(lf, lf[0], n % 2, n % 3, lf[3], lf[5], lf[7]);
    end
    // Drain the last four words through zero-word markers
    for (int n = 0; n < 5; n++) drive_pixel(16'h0000, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule